// File: doc/BRIEF.md
# Sector Data Field Framer

This block builds and checks the data portion of one disk sector at byte level. It has a write path and a read path that run independently. Both paths are paced by a byte-slot strobe, `byte_tick`, which marks the moment the serializer takes or delivers one byte.

On a write, the block sends a run of zero fill bytes, then a sync byte tagged with the missing-clock mark, then a data mark. It follows these with the payload, which it pulls from an upstream valid/ready source one byte per slot. A two-byte CRC comes next, and a short zero trailer ends the field. The write gate stays high for the whole field.

On a read, the block watches the incoming byte stream for a marked sync followed by the data mark. It then hands the payload bytes onward, checks the CRC that closes the field, and reports a mismatch. The field length on both paths is programmed as a count of 32-byte blocks. Bit-level encoding, header search and memory access are handled outside this block.

Top module: `sdf_framer`

## Requirements
- R1: After a synchronous reset, `wr_gate`, `wr_mark`, `wr_byte`, `in_ready`, `out_valid`, `wr_done`, `rd_done`, `wr_underrun` and `crc_error` are all 0.
- R2: After an accepted write start, the write output changes only on `byte_tick` cycles. It emits PRE_N bytes of 0x00, then 0xA1 with `wr_mark`=1, then 0xF8 with `wr_mark`=0. `wr_mark` is 1 for no other byte.
- R3: The payload that follows is exactly `wr_blocks`×32 bytes. It is taken in order from `in_data`, and a byte is consumed when `in_valid` and `in_ready` are both high. `in_ready` is high only on a `byte_tick` cycle of a payload slot.
- R4: Right after the payload come two CRC bytes, high byte first. The CRC uses polynomial 0x1021, preset 0xFFFF, with bits fed most significant first. It covers 0xA1, 0xF8 and every payload byte as sent.
- R5: POST_N bytes of 0x00 follow the CRC with `wr_gate` high. `wr_done` pulses for one clock together with the last of them. `wr_gate` drops on the next `byte_tick`.
- R6: If `in_valid` is low in a payload slot, 0x00 is sent in that slot and `wr_underrun` is set. The flag stays set until the next accepted write start clears it.
- R7: On a `rd_valid` cycle, the read path delivers payload bytes on `out_data`/`out_valid` only after it has seen a marked 0xA1 directly followed by an unmarked 0xF8. An unmarked 0xA1, or any other byte, while hunting is ignored. A repeated marked 0xA1 restarts the sync.
- R8: After `rd_blocks`×32 payload bytes, the read path takes two CRC bytes, pulses `rd_done` once, and sets `crc_error` if the residue over sync, mark, payload and CRC is nonzero. `crc_error` is cleared by the next accepted read start.
- R9: A start with a block count of 0, or a start while that path is busy, is ignored.
- R10: The write and read paths work concurrently. The write output, looped back into the read input, is recovered with the same payload and `crc_error`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_tick | input | 1 | Byte slot strobe for the write path |
| wr_start | input | 1 | Start a write field |
| wr_blocks | input | BLK_W | Write payload length in 32-byte blocks |
| in_data | input | 8 | Payload byte from the source |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Payload byte taken this cycle |
| wr_byte | output | 8 | Byte to the serializer |
| wr_mark | output | 1 | Missing-clock mark for `wr_byte` |
| wr_gate | output | 1 | Write gate |
| wr_done | output | 1 | One-clock pulse on the last trailer byte |
| wr_underrun | output | 1 | Sticky: payload slot had no byte |
| rd_start | input | 1 | Arm the read path |
| rd_blocks | input | BLK_W | Read payload length in 32-byte blocks |
| rd_valid | input | 1 | Incoming byte valid |
| rd_byte | input | 8 | Incoming byte |
| rd_mark | input | 1 | Incoming byte carried a missing-clock mark |
| out_data | output | 8 | Recovered payload byte |
| out_valid | output | 1 | `out_data` valid |
| rd_done | output | 1 | One-clock pulse when the CRC has been checked |
| crc_error | output | 1 | CRC residue nonzero on the last read |

## Verification
The write path emitting a byte and the read path consuming one fall in the same clock. This happens whenever the write output is fed straight back into the read input, because every byte slot then drives both state machines at once. The bench runs whole fields this way and judges each emitted byte against a behavioural stream model at every slot, and each recovered byte against the payload queue. A second collision is a write start landing while a field is in flight. It is provoked in mid-payload, and it is judged by the emitted stream staying byte-for-byte as modelled.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam logic [7:0]  SYNC_BYTE  = 8'hA1;
  localparam logic [7:0]  DMARK_BYTE = 8'hF8;
  localparam logic [7:0]  FILL_BYTE  = 8'h00;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h1021;

  typedef enum logic [2:0] {
    WS_IDLE, WS_PRE, WS_SYNC, WS_MARK, WS_DATA, WS_CRCH, WS_CRCL, WS_POST
  } wr_state_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_HUNT, RS_MARK, RS_DATA, RS_CRCH, RS_CRCL
  } rd_state_t;

  // One byte of CRC, most significant bit first.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/sdf_tx.sv
module sdf_tx
  import sdf_pkg::*;
#(
  parameter int BLK_W    = 4,
  parameter int BLK_LOG2 = 5,
  parameter int PRE_N    = 3,
  parameter int POST_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_tick,
  input  logic             start,
  input  logic [BLK_W-1:0] blocks,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       tx_byte,
  output logic             tx_mark,
  output logic             tx_gate,
  output logic             tx_done,
  output logic             underrun
);
  localparam int CNT_W = BLK_W + BLK_LOG2;

  wr_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk_q;
  logic [15:0]      crc;
  logic [7:0]       pick;
  logic             accept;

  assign accept   = start && (st == WS_IDLE) && (blocks != '0);
  assign in_ready = (st == WS_DATA) && byte_tick;

  always_comb begin
    pick = in_valid ? in_data : FILL_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= WS_IDLE;
      cnt      <= '0;
      blk_q    <= '0;
      crc      <= CRC_SEED;
      tx_byte  <= FILL_BYTE;
      tx_mark  <= 1'b0;
      tx_gate  <= 1'b0;
      tx_done  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (accept) begin
        st       <= WS_PRE;
        cnt      <= CNT_W'(PRE_N - 1);
        blk_q    <= blocks;
        crc      <= CRC_SEED;
        underrun <= 1'b0;
      end else if (byte_tick) begin
        tx_mark <= 1'b0;
        tx_gate <= (st != WS_IDLE);
        case (st)
          WS_IDLE: tx_byte <= FILL_BYTE;
          WS_PRE: begin
            tx_byte <= FILL_BYTE;
            if (cnt == '0) st <= WS_SYNC;
            else           cnt <= cnt - 1'b1;
          end
          WS_SYNC: begin
            tx_byte <= SYNC_BYTE;
            tx_mark <= 1'b1;
            crc     <= crc_step(crc, SYNC_BYTE);
            st      <= WS_MARK;
          end
          WS_MARK: begin
            tx_byte <= DMARK_BYTE;
            crc     <= crc_step(crc, DMARK_BYTE);
            cnt     <= {blk_q, {BLK_LOG2{1'b0}}} - CNT_W'(1);
            st      <= WS_DATA;
          end
          WS_DATA: begin
            tx_byte <= pick;
            crc     <= crc_step(crc, pick);
            if (!in_valid) underrun <= 1'b1;
            if (cnt == '0) st <= WS_CRCH;
            else           cnt <= cnt - 1'b1;
          end
          WS_CRCH: begin
            tx_byte <= crc[15:8];
            st      <= WS_CRCL;
          end
          WS_CRCL: begin
            tx_byte <= crc[7:0];
            cnt     <= CNT_W'(POST_N - 1);
            st      <= WS_POST;
          end
          WS_POST: begin
            tx_byte <= FILL_BYTE;
            if (cnt == '0) begin
              st      <= WS_IDLE;
              tx_done <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: st <= WS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdf_rx.sv
module sdf_rx
  import sdf_pkg::*;
#(
  parameter int BLK_W    = 4,
  parameter int BLK_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] blocks,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_mark,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             rx_done,
  output logic             crc_error
);
  localparam int CNT_W = BLK_W + BLK_LOG2;

  rd_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk_q;
  logic [15:0]      crc;
  logic [15:0]      crc_nx;
  logic             accept;
  logic             is_sync;
  logic             is_dmark;

  assign accept   = start && (st == RS_IDLE) && (blocks != '0);
  assign is_sync  = rx_mark && (rx_byte == SYNC_BYTE);
  assign is_dmark = !rx_mark && (rx_byte == DMARK_BYTE);

  always_comb begin
    crc_nx = crc_step(crc, rx_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RS_IDLE;
      cnt       <= '0;
      blk_q     <= '0;
      crc       <= CRC_SEED;
      out_data  <= '0;
      out_valid <= 1'b0;
      rx_done   <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      rx_done   <= 1'b0;
      if (accept) begin
        st        <= RS_HUNT;
        blk_q     <= blocks;
        crc_error <= 1'b0;
      end else if (rx_valid) begin
        case (st)
          RS_HUNT: begin
            if (is_sync) begin
              crc <= crc_step(CRC_SEED, SYNC_BYTE);
              st  <= RS_MARK;
            end
          end
          RS_MARK: begin
            if (is_dmark) begin
              crc <= crc_nx;
              cnt <= {blk_q, {BLK_LOG2{1'b0}}} - CNT_W'(1);
              st  <= RS_DATA;
            end else if (is_sync) begin
              crc <= crc_step(CRC_SEED, SYNC_BYTE);
            end else begin
              st <= RS_HUNT;
            end
          end
          RS_DATA: begin
            out_data  <= rx_byte;
            out_valid <= 1'b1;
            crc       <= crc_nx;
            if (cnt == '0) st <= RS_CRCH;
            else           cnt <= cnt - 1'b1;
          end
          RS_CRCH: begin
            crc <= crc_nx;
            st  <= RS_CRCL;
          end
          RS_CRCL: begin
            crc_error <= (crc_nx != 16'h0000);
            rx_done   <= 1'b1;
            st        <= RS_IDLE;
          end
          default: st <= RS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdf_framer.sv
module sdf_framer #(
  parameter int BLK_W  = 4,
  parameter int PRE_N  = 3,
  parameter int POST_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_tick,
  input  logic             wr_start,
  input  logic [BLK_W-1:0] wr_blocks,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       wr_byte,
  output logic             wr_mark,
  output logic             wr_gate,
  output logic             wr_done,
  output logic             wr_underrun,
  input  logic             rd_start,
  input  logic [BLK_W-1:0] rd_blocks,
  input  logic             rd_valid,
  input  logic [7:0]       rd_byte,
  input  logic             rd_mark,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             rd_done,
  output logic             crc_error
);
  localparam int BLK_LOG2 = 5;

  sdf_tx #(
    .BLK_W(BLK_W), .BLK_LOG2(BLK_LOG2), .PRE_N(PRE_N), .POST_N(POST_N)
  ) u_tx (
    .clk(clk), .rst(rst), .byte_tick(byte_tick),
    .start(wr_start), .blocks(wr_blocks),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx_byte(wr_byte), .tx_mark(wr_mark), .tx_gate(wr_gate),
    .tx_done(wr_done), .underrun(wr_underrun)
  );

  sdf_rx #(
    .BLK_W(BLK_W), .BLK_LOG2(BLK_LOG2)
  ) u_rx (
    .clk(clk), .rst(rst),
    .start(rd_start), .blocks(rd_blocks),
    .rx_valid(rd_valid), .rx_byte(rd_byte), .rx_mark(rd_mark),
    .out_data(out_data), .out_valid(out_valid),
    .rx_done(rd_done), .crc_error(crc_error)
  );
endmodule

// File: rtl/sdf_framer_chk.sv
module sdf_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_tick,
  input logic       wr_start,
  input logic       in_ready,
  input logic [7:0] wr_byte,
  input logic       wr_mark,
  input logic       wr_gate,
  input logic       wr_done,
  input logic       wr_underrun,
  input logic       rd_valid,
  input logic       out_valid,
  input logic       rd_done
);
  // R3: payload is pulled only in a byte slot
  a_r3_ready_on_tick: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> byte_tick);

  // R2: the mark flag travels only with the sync byte inside the gate
  a_r2_mark_is_sync: assert property (@(posedge clk) disable iff (rst)
    wr_mark |-> (wr_gate && wr_byte == 8'hA1));

  // R5: completion pulse coincides with a gated trailer byte
  a_r5_done_in_gate: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> (wr_gate && wr_byte == 8'h00));

  // R2: write outputs move only on a byte slot
  a_r2_gate_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_tick) |-> $stable(wr_gate));

  // R6: underrun is sticky until a new write start
  a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (wr_underrun && !wr_start) |=> wr_underrun);

  // R7: a recovered byte always comes from an incoming byte
  a_r7_out_after_in: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_valid));

  // R8: read completion is a single-clock pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);
endmodule

bind sdf_framer sdf_framer_chk u_chk (
  .clk(clk), .rst(rst), .byte_tick(byte_tick), .wr_start(wr_start),
  .in_ready(in_ready), .wr_byte(wr_byte), .wr_mark(wr_mark),
  .wr_gate(wr_gate), .wr_done(wr_done), .wr_underrun(wr_underrun),
  .rd_valid(rd_valid), .out_valid(out_valid), .rd_done(rd_done)
);

// File: tb/test_sdf_framer.sv
module test_sdf_framer;
  localparam int BLK_W  = 4;
  localparam int PRE_N  = 3;
  localparam int POST_N = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst = 1'b1, byte_tick = 1'b0;
  logic             wr_start = 1'b0, in_valid = 1'b0;
  logic [BLK_W-1:0] wr_blocks = '0, rd_blocks = '0;
  logic [7:0]       in_data = '0, rd_byte = '0;
  logic             rd_start = 1'b0, rd_valid = 1'b0, rd_mark = 1'b0;
  logic             in_ready, wr_mark, wr_gate, wr_done, wr_underrun;
  logic [7:0]       wr_byte, out_data;
  logic             out_valid, rd_done, crc_error;

  sdf_framer #(.BLK_W(BLK_W), .PRE_N(PRE_N), .POST_N(POST_N)) i_sdf_framer (
    .clk(clk), .rst(rst), .byte_tick(byte_tick),
    .wr_start(wr_start), .wr_blocks(wr_blocks),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .wr_byte(wr_byte), .wr_mark(wr_mark), .wr_gate(wr_gate),
    .wr_done(wr_done), .wr_underrun(wr_underrun),
    .rd_start(rd_start), .rd_blocks(rd_blocks),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_mark(rd_mark),
    .out_data(out_data), .out_valid(out_valid),
    .rd_done(rd_done), .crc_error(crc_error)
  );

  int checks = 0, errors = 0;
  logic [8:0] wexp[$];
  logic [7:0] rexp[$];
  logic [7:0] src[$];
  logic [8:0] inj[$];
  int  hole = -1, slot = 0, tdiv = 0;
  int  wr_done_cnt = 0, rd_done_cnt = 0;
  bit  loop_en = 1'b0, last_tick = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] v = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = v[15] ^ b[7-k];
      v = {v[14:0], 1'b0};
      if (fb) v = v ^ 16'h1021;
    end
    return v;
  endfunction

  // One clock: check results of the last edge, then drive the next one.
  task automatic step;
    logic [8:0] e;
    bit exp_done;
    @(negedge clk);
    exp_done = 1'b0;
    if (last_tick) begin
      if (wexp.size() > 0) begin
        e = wexp.pop_front();
        chk(wr_gate == 1'b1 && wr_byte == e[7:0] && wr_mark == e[8],
            "R2/R3/R4", "write slot", {wr_mark, wr_byte}, e);
        exp_done = (wexp.size() == 0);
      end else begin
        chk(wr_gate == 1'b0, "R5", "gate idle", wr_gate, 0);
      end
    end
    chk(wr_done == exp_done, "R5", "wr_done", wr_done, exp_done);
    if (out_valid) begin
      if (rexp.size() == 0) chk(1'b0, "R7", "unexpected out", out_data, 0);
      else begin
        e = {1'b0, rexp.pop_front()};
        chk(out_data == e[7:0], "R7", "read byte", out_data, e[7:0]);
      end
    end
    if (rd_done) rd_done_cnt++;
    if (wr_done) wr_done_cnt++;
    tdiv++;
    byte_tick = (tdiv % 4 == 0);
    if (loop_en) begin
      rd_valid = byte_tick && wr_gate;
      rd_byte  = wr_byte;
      rd_mark  = wr_mark;
    end else if (byte_tick && inj.size() > 0) begin
      e = inj.pop_front();
      rd_valid = 1'b1; rd_byte = e[7:0]; rd_mark = e[8];
    end else begin
      rd_valid = 1'b0;
    end
    in_valid = (src.size() > 0) && (slot != hole);
    in_data  = (src.size() > 0) ? src[0] : 8'h00;
    #1;
    if (in_ready) begin
      if (in_valid) void'(src.pop_front());
      slot++;
    end
    last_tick = byte_tick;
  endtask

  // Build source payload, expected write stream and expected read bytes.
  task automatic plan_field(input int nblk, input int hole_at, input int seed);
    logic [7:0] cp[$];
    logic [15:0] c = 16'hFFFF;
    logic [7:0] b;
    int n = nblk * 32;
    src.delete(); wexp.delete(); rexp.delete();
    for (int i = 0; i < n; i++) src.push_back(8'((i * 37 + seed) & 255));
    cp = src;
    slot = 0; hole = hole_at;
    for (int i = 0; i < PRE_N; i++) wexp.push_back(9'h000);
    wexp.push_back(9'h1A1); c = ref_crc(c, 8'hA1);
    wexp.push_back(9'h0F8); c = ref_crc(c, 8'hF8);
    for (int i = 0; i < n; i++) begin
      b = (i == hole_at) ? 8'h00 : cp.pop_front();
      wexp.push_back({1'b0, b}); rexp.push_back(b); c = ref_crc(c, b);
    end
    wexp.push_back({1'b0, c[15:8]});
    wexp.push_back({1'b0, c[7:0]});
    for (int i = 0; i < POST_N; i++) wexp.push_back(9'h000);
  endtask

  task automatic loop_field(input int nblk, input int hole_at, input int seed,
                            input bit poke_busy);
    int rd0 = rd_done_cnt, wd0 = wr_done_cnt;
    loop_en = 1'b1;
    rd_blocks = BLK_W'(nblk); rd_start = 1'b1; step(); rd_start = 1'b0;
    wr_blocks = BLK_W'(nblk);
    wr_start = 1'b1; step(); wr_start = 1'b0;
    plan_field(nblk, hole_at, seed);
    step();
    chk(wr_underrun == 1'b0, "R6", "underrun cleared by start", wr_underrun, 0);
    if (poke_busy) begin
      repeat (60) step();
      wr_blocks = 3; wr_start = 1'b1; step(); wr_start = 1'b0;  // R9 busy start
    end
    while (wexp.size() > 0) step();
    repeat (24) step();
    chk(wr_done_cnt == wd0 + 1, "R5", "one write done", wr_done_cnt - wd0, 1);
    chk(rd_done_cnt == rd0 + 1, "R10", "loopback read done", rd_done_cnt - rd0, 1);
    chk(rexp.size() == 0, "R10", "all bytes recovered", rexp.size(), 0);
    chk(crc_error == 1'b0, "R10", "loopback crc", crc_error, 0);
    chk(wr_underrun == (hole_at >= 0), "R6", "underrun flag", wr_underrun, hole_at >= 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c;
    int rd0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(wr_gate == 0 && wr_mark == 0 && wr_byte == 0, "R1", "write idle", wr_byte, 0);
    chk(in_ready == 0 && out_valid == 0, "R1", "handshakes idle", in_ready, 0);
    chk(wr_done == 0 && rd_done == 0, "R1", "done low", rd_done, 0);
    chk(wr_underrun == 0 && crc_error == 0, "R1", "flags low", crc_error, 0);

    // R9: zero-length start ignored
    wr_blocks = 0; wr_start = 1'b1; step(); wr_start = 1'b0;
    repeat (40) step();
    chk(wr_done_cnt == 0, "R9", "zero start no field", wr_done_cnt, 0);
    chk(wr_gate == 0, "R9", "zero start gate", wr_gate, 0);

    // R2..R5, R9, R10: one block, start poked while busy
    loop_field(1, -1, 3, 1'b1);
    // R6: two blocks with an underrun slot
    loop_field(2, 5, 11, 1'b0);
    // R6 clear, R10: three blocks clean
    loop_field(3, -1, 90, 1'b0);

    // R7/R8: injected stream with junk and a corrupted CRC
    loop_en = 1'b0;
    rd_blocks = 1; rd_start = 1'b1; step(); rd_start = 1'b0;
    rd0 = rd_done_cnt;
    rexp.delete(); inj.delete();
    inj.push_back(9'h0A1); inj.push_back(9'h0F8);  // unmarked sync: ignored
    inj.push_back(9'h1A1); inj.push_back(9'h055);  // broken pair: hunt again
    inj.push_back(9'h1A1); inj.push_back(9'h1A1); inj.push_back(9'h0F8);
    c = ref_crc(ref_crc(16'hFFFF, 8'hA1), 8'hF8);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b = 8'((i * 13 + 161) & 255);
      inj.push_back({1'b0, b}); rexp.push_back(b); c = ref_crc(c, b);
    end
    inj.push_back({1'b0, c[15:8]}); inj.push_back({1'b0, c[7:0] ^ 8'h01});
    while (inj.size() > 0) step();
    repeat (8) step();
    chk(rexp.size() == 0, "R7", "payload after marked pair only", rexp.size(), 0);
    chk(rd_done_cnt == rd0 + 1, "R8", "read done once", rd_done_cnt - rd0, 1);
    chk(crc_error == 1'b1, "R8", "bad crc flagged", crc_error, 1);

    // R8: good CRC clears the flag
    rd_start = 1'b1; step(); rd_start = 1'b0;
    chk(crc_error == 1'b0, "R8", "start clears crc_error", crc_error, 0);
    inj.push_back(9'h1A1); inj.push_back(9'h0F8);
    c = ref_crc(ref_crc(16'hFFFF, 8'hA1), 8'hF8);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b = 8'(255 - i);
      inj.push_back({1'b0, b}); rexp.push_back(b); c = ref_crc(c, b);
    end
    inj.push_back({1'b0, c[15:8]}); inj.push_back({1'b0, c[7:0]});
    while (inj.size() > 0) step();
    repeat (8) step();
    chk(rexp.size() == 0, "R7", "second read payload", rexp.size(), 0);
    chk(crc_error == 1'b0, "R8", "good crc", crc_error, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule